// File: doc/BRIEF.md
# Signaling Change Event Queue with Interrupt Causes

This block sits beside a multi-channel receive framer and stores signaling change events until a processor collects them. An event is a channel number and the new signaling bits for that channel. Events enter through a one-cycle write strobe. The oldest stored event is always shown at the head outputs, and a pop strobe removes it. Up to 64 events can be held.

Three conditions raise an interrupt:

- **Depth:** the queue holds more events than a programmed threshold.
- **Timer:** a programmed timer expires while events are still waiting.
- **Overflow:** an event arrives when the queue is full. The whole queue is then discarded.

Each condition latches a sticky status bit. A mask register selects which status bits can drive the single active-high interrupt output. Status bits are cleared in one of two ways, chosen by a control bit: reading the status register clears them, or software writes 1 to each bit it wants cleared.

Software reaches the status, mask, threshold, timer and control settings through a simple register port. The port has a write strobe, a read strobe, an address and 16-bit data. Read data is combinational on the address.

Top module: `cos_event_queue`

## Requirements
- R1: Events leave the queue in the order they were written. `head_valid` is 1 whenever at least one event is stored, and `head_chan`/`head_sig` show the oldest event. A pop removes that event on the clock edge where the pop strobe is high.
- R2: A pop while the queue is empty changes nothing. While the queue is empty, the head is flagged invalid: `head_valid`=0 and `head_chan`=`head_sig`=0.
- R3: A write that arrives while 64 events are stored, with no pop in the same cycle, is an overflow. On that edge the incoming event is dropped, the queue becomes empty, and status bit 0 is set.
- R4: Status bit 2 (depth) is set at the clock edge that follows any cycle in which the stored count is strictly greater than the threshold register. A count equal to the threshold does not set it.
- R5: The timer counts clock cycles from 0 up to the terminal value T, then restarts from 0. It is held at 0 while the queue is empty. After a write into an empty queue, status bit 1 (timer) becomes visible T+1 clock edges after the write edge.
- R6: Status bit 1 is never set while the queue stays empty, whatever the terminal value.
- R7: When the control bit is 1 (clear-on-read mode), a read of the status register returns the current bits and clears them at that clock edge.
- R8: When the control bit is 0, reading the status register does not clear it. Writing 1 to a status bit clears that bit, and writing 0 leaves it unchanged.
- R9: If a clear and a new occurrence of the same cause fall in the same cycle, the status bit stays set.
- R10: `irq` is 1 exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 does not stop the status bit from being recorded.
- R11: Reset values:
  - status = 0
  - mask = 3'b111
  - threshold = 48
  - timer terminal = 1023
  - control = 1
- R12: Register map (3-bit address):
  - 0: status — bit 2 depth, bit 1 timer, bit 0 overflow
  - 1: mask — same bit layout as status
  - 2: threshold, bits 6:0
  - 3: timer terminal, bits 15:0
  - 4: control, bit 0 = clear-on-read enable

  Reserved bits read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event write strobe |
| evt_chan | input | 5 | Channel number of the event |
| evt_sig | input | 4 | New signaling bits of the event |
| pop | input | 1 | Removes the head event |
| head_valid | output | 1 | Head holds a stored event |
| head_chan | output | 5 | Channel number of the head event |
| head_sig | output | 4 | Signaling bits of the head event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The hardest case to reach from the ports is an overflow while clear-on-read is switched off. The bench has to fill all 64 entries one write at a time, checking them against the scoreboard, and then present one more write with no pop. It then confirms four things: the head is invalid, the interrupt is raised, repeated status reads keep the bit set, and only a write of 1 removes it. The timer case is just as narrow. The bench places one event into an empty queue with a small terminal value and checks the interrupt on the exact edge where it first becomes visible.

// File: rtl/cos_evq_pkg.sv
package cos_evq_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NCAUSE  = 3;

  localparam int unsigned CAUSE_OVF   = 0;
  localparam int unsigned CAUSE_TIMER = 1;
  localparam int unsigned CAUSE_DEPTH = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 3'd0,
    REG_MASK   = 3'd1,
    REG_THRESH = 3'd2,
    REG_TIMER  = 3'd3,
    REG_CTRL   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/cos_evq_fifo.sv
module cos_evq_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 9,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic [CW-1:0] fill,
  output logic          ovf_evt
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          empty, full, do_pop, do_push;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) ptr_inc = '0;
    else                     ptr_inc = p + AW'(1);
  endfunction

  assign empty   = (fill_q == '0);
  assign full    = (fill_q == CW'(DEPTH));
  assign do_pop  = rd_en && !empty;
  assign ovf_evt = wr_en && full && !do_pop;
  assign do_push = wr_en && !ovf_evt;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    fill_d = fill_q;
    if (ovf_evt) begin
      wptr_d = rptr_q;
      fill_d = '0;
    end else begin
      if (do_push) wptr_d = ptr_inc(wptr_q);
      if (do_pop)  rptr_d = ptr_inc(rptr_q);
      case ({do_push, do_pop})
        2'b10:   fill_d = fill_q + CW'(1);
        2'b01:   fill_d = fill_q - CW'(1);
        default: fill_d = fill_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= wr_data;
  end

  assign rd_valid = !empty;
  assign rd_data  = empty ? '0 : mem_q[rptr_q];
  assign fill     = fill_q;
endmodule

// File: rtl/cos_evq_timer.sv
module cos_evq_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] term,
  output logic          fire
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          at_term;

  assign at_term = (cnt_q == term);
  assign fire    = run && at_term;

  always_comb begin
    if (!run)         cnt_d = '0;
    else if (at_term) cnt_d = '0;
    else              cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cos_evq_irq.sv
module cos_evq_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] sts,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] sts_q, sts_d, mask_q, mask_d;
  logic [N-1:0] live;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cause
      // a new occurrence overrides a clear in the same cycle
      assign sts_d[g] = set_evt[g] | (sts_q[g] & ~clr_req[g]);
      assign live[g]  = sts_q[g] & ~mask_q[g];
    end
  endgenerate

  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '1;
    end else begin
      sts_q  <= sts_d;
      mask_q <= mask_d;
    end
  end

  assign sts  = sts_q;
  assign mask = mask_q;
  assign irq  = |live;
endmodule

// File: rtl/cos_evq_regs.sv
module cos_evq_regs
  import cos_evq_pkg::*;
#(
  parameter int unsigned CW       = 7,
  parameter int unsigned TW       = 16,
  parameter int unsigned THR_RST  = 48,
  parameter int unsigned TERM_RST = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCAUSE-1:0] sts,
  input  logic [NCAUSE-1:0] mask,
  output logic              mask_we,
  output logic [NCAUSE-1:0] clr_req,
  output logic [CW-1:0]     thr,
  output logic [TW-1:0]     term,
  output logic              cor_en
);
  logic [CW-1:0] thr_q, thr_d;
  logic [TW-1:0] term_q, term_d;
  logic          cor_q, cor_d;
  logic          sel_sts, sel_mask, sel_thr, sel_tmr, sel_ctl;

  assign sel_sts  = (reg_addr == REG_STATUS);
  assign sel_mask = (reg_addr == REG_MASK);
  assign sel_thr  = (reg_addr == REG_THRESH);
  assign sel_tmr  = (reg_addr == REG_TIMER);
  assign sel_ctl  = (reg_addr == REG_CTRL);

  assign mask_we = reg_wr && sel_mask;

  always_comb begin
    thr_d  = thr_q;
    term_d = term_q;
    cor_d  = cor_q;
    if (reg_wr && sel_thr) thr_d  = reg_wdata[CW-1:0];
    if (reg_wr && sel_tmr) term_d = reg_wdata[TW-1:0];
    if (reg_wr && sel_ctl) cor_d  = reg_wdata[0];
  end

  always_comb begin
    clr_req = '0;
    if (cor_q && reg_rd && sel_sts)
      clr_req = '1;
    else if (!cor_q && reg_wr && sel_sts)
      clr_req = reg_wdata[NCAUSE-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_STATUS: reg_rdata[NCAUSE-1:0] = sts;
      REG_MASK:   reg_rdata[NCAUSE-1:0] = mask;
      REG_THRESH: reg_rdata[CW-1:0]     = thr_q;
      REG_TIMER:  reg_rdata[TW-1:0]     = term_q;
      REG_CTRL:   reg_rdata[0]          = cor_q;
      default:    reg_rdata             = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= CW'(THR_RST);
      term_q <= TW'(TERM_RST);
      cor_q  <= 1'b1;
    end else begin
      thr_q  <= thr_d;
      term_q <= term_d;
      cor_q  <= cor_d;
    end
  end

  assign thr    = thr_q;
  assign term   = term_q;
  assign cor_en = cor_q;
endmodule

// File: rtl/cos_event_queue.sv
module cos_event_queue
  import cos_evq_pkg::*;
#(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned CHAN_W   = 5,
  parameter int unsigned SIG_W    = 4,
  parameter int unsigned TMR_W    = 16,
  parameter int unsigned THR_RST  = 48,
  parameter int unsigned TERM_RST = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CHAN_W-1:0] evt_chan,
  input  logic [SIG_W-1:0]  evt_sig,
  input  logic              pop,
  output logic              head_valid,
  output logic [CHAN_W-1:0] head_chan,
  output logic [SIG_W-1:0]  head_sig,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq
);
  localparam int unsigned EW = CHAN_W + SIG_W;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [EW-1:0]     head_word;
  logic [CW-1:0]     fill_cnt;
  logic              ovf_evt, tmr_fire;
  logic [CW-1:0]     thr_w;
  logic [TMR_W-1:0]  term_w;
  logic              cor_en_w, mask_we;
  logic [NCAUSE-1:0] set_vec, clr_vec, sts_q, mask_w;

  cos_evq_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(evt_valid), .wr_data({evt_chan, evt_sig}),
    .rd_en(pop), .rd_data(head_word), .rd_valid(head_valid),
    .fill(fill_cnt), .ovf_evt(ovf_evt)
  );

  assign head_chan = head_word[EW-1:SIG_W];
  assign head_sig  = head_word[SIG_W-1:0];

  cos_evq_timer #(.TW(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(fill_cnt != '0), .term(term_w), .fire(tmr_fire)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[CAUSE_OVF]   = ovf_evt;
    set_vec[CAUSE_TIMER] = tmr_fire;
    set_vec[CAUSE_DEPTH] = (fill_cnt > thr_w);
  end

  cos_evq_regs #(
    .CW(CW), .TW(TMR_W), .THR_RST(THR_RST), .TERM_RST(TERM_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sts(sts_q), .mask(mask_w), .mask_we(mask_we), .clr_req(clr_vec),
    .thr(thr_w), .term(term_w), .cor_en(cor_en_w)
  );

  cos_evq_irq #(.N(NCAUSE)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_evt(set_vec), .clr_req(clr_vec),
    .mask_we(mask_we), .mask_wdata(reg_wdata[NCAUSE-1:0]),
    .sts(sts_q), .mask(mask_w), .irq(irq)
  );
endmodule

// File: rtl/cos_event_queue_chk.sv
module cos_event_queue_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_valid,
  input logic          pop,
  input logic          head_valid,
  input logic [CW-1:0] fill,
  input logic [CW-1:0] thr,
  input logic [2:0]    sts
);
  // R1: count never exceeds capacity and matches head validity
  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (fill <= CW'(DEPTH)) && (head_valid == (fill != '0)));

  // R2: a lone pop on an empty queue leaves it empty
  a_r2_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && pop && !evt_valid) |=> (fill == '0));

  // R3: write into a full queue flushes it and records overflow
  a_r3_overflow_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && fill == CW'(DEPTH) && !pop) |=> (fill == '0 && sts[0]));

  // R4 / R9: over-threshold count always leaves the depth bit set
  a_r4_depth_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fill > thr) |=> sts[2]);

  // R5: timer bit only rises after a cycle with stored events
  a_r5_timer_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> ($past(fill) != '0));

  // R6: empty queue never raises the timer bit
  a_r6_no_empty_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && !sts[1]) |=> !sts[1]);
endmodule

bind cos_event_queue cos_event_queue_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .pop(pop),
  .head_valid(head_valid), .fill(fill_cnt), .thr(thr_w), .sts(sts_q)
);

// File: tb/cos_event_queue_test.sv
module cos_event_queue_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid, pop, reg_wr, reg_rd;
  logic [4:0]  evt_chan;
  logic [3:0]  evt_sig;
  logic        head_valid, irq;
  logic [4:0]  head_chan;
  logic [3:0]  head_sig;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  logic [8:0] sb[$];

  cos_event_queue uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_chan(evt_chan),
    .evt_sig(evt_sig), .pop(pop), .head_valid(head_valid),
    .head_chan(head_chan), .head_sig(head_sig), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd_reg(a, d);
    chk(req, 32'(d), 32'(exp));
  endtask

  // driver: push event and record expectation
  task automatic push_evt(input logic [4:0] c, input logic [3:0] s, input bit expect_kept);
    evt_valid = 1'b1; evt_chan = c; evt_sig = s;
    if (expect_kept) sb.push_back({c, s});
    tick();
    evt_valid = 1'b0;
  endtask

  // monitor: compare head against scoreboard, then pop
  task automatic pop_chk(input string req);
    logic [8:0] e;
    if (sb.size() == 0) begin
      chk(req, 32'(head_valid), 32'd0);
    end else begin
      e = sb.pop_front();
      chk(req, {23'd0, head_valid, head_chan, head_sig}, {23'd0, 1'b1, e});
    end
    pop = 1'b1;
    tick();
    pop = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; pop = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    evt_chan = '0; evt_sig = '0; reg_addr = '0; reg_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R11 reset state
    chk("R11 irq", 32'(irq), 0);
    chk("R2 head invalid at reset", {head_valid, head_chan, head_sig}, 0);
    rd_chk("R11 status", 3'd0, 16'h0000);
    rd_chk("R11 mask", 3'd1, 16'h0007);
    rd_chk("R11 thresh", 3'd2, 16'd48);
    rd_chk("R11 term", 3'd3, 16'd1023);
    rd_chk("R11 ctrl", 3'd4, 16'd1);

    // R1 ordering
    wr_reg(3'd3, 16'd60000);
    push_evt(5'd3, 4'hA, 1'b1);
    push_evt(5'd31, 4'h1, 1'b1);
    push_evt(5'd0, 4'hF, 1'b1);
    push_evt(5'd17, 4'h6, 1'b1);
    push_evt(5'd9, 4'h0, 1'b1);
    for (int i = 0; i < 5; i++) pop_chk("R1 order");
    // R2 pop on empty
    pop_chk("R2 empty pop");
    chk("R2 empty head data", {head_valid, head_chan, head_sig}, 0);
    push_evt(5'd21, 4'h5, 1'b1);
    pop_chk("R2 state intact after empty pop");

    // R4 depth threshold
    wr_reg(3'd2, 16'd3);
    push_evt(5'd1, 4'h1, 1'b1);
    push_evt(5'd2, 4'h2, 1'b1);
    push_evt(5'd3, 4'h3, 1'b1);
    tick();
    rd_chk("R4 equal count no set", 3'd0, 16'h0000);
    push_evt(5'd4, 4'h4, 1'b1);
    tick();
    rd_chk("R4 over threshold", 3'd0, 16'h0004);
    rd_chk("R9 set wins over read clear", 3'd0, 16'h0004);
    for (int i = 0; i < 4; i++) pop_chk("R1 drain");
    rd_chk("R7 read returns bits", 3'd0, 16'h0004);
    rd_chk("R7 cleared by read", 3'd0, 16'h0000);
    wr_reg(3'd2, 16'd48);

    // R5 / R6 timer
    wr_reg(3'd3, 16'd20);
    wr_reg(3'd1, 16'h0005);
    repeat (50) tick();
    chk("R6 empty no timer irq", 32'(irq), 0);
    rd_chk("R6 empty no timer status", 3'd0, 16'h0000);
    push_evt(5'd7, 4'h9, 1'b1);
    repeat (20) tick();
    chk("R5 before terminal", 32'(irq), 0);
    tick();
    chk("R5 timer irq", 32'(irq), 1);
    rd_chk("R7 timer status read", 3'd0, 16'h0002);
    chk("R7 irq drops after clear", 32'(irq), 0);
    wr_reg(3'd1, 16'h0007);
    repeat (25) tick();
    chk("R10 masked irq", 32'(irq), 0);
    rd_chk("R10 masked still recorded", 3'd0, 16'h0002);
    wr_reg(3'd3, 16'd60000);
    pop_chk("R1 timer event");
    tick();
    rd_chk("R7 clear", 3'd0, 16'h0000);

    // R3 / R8 overflow with write-one-to-clear
    wr_reg(3'd2, 16'd64);
    wr_reg(3'd1, 16'h0006);
    wr_reg(3'd4, 16'h0000);
    for (int i = 0; i < 64; i++) push_evt(5'(i), 4'(i ^ 5), 1'b1);
    chk("R3 full no irq", 32'(irq), 0);
    chk("R1 full head", {head_valid, head_chan, head_sig}, {1'b1, 5'd0, 4'd5});
    push_evt(5'd30, 4'hC, 1'b0);
    sb.delete();
    chk("R3 flushed", 32'(head_valid), 0);
    chk("R3 overflow irq", 32'(irq), 1);
    rd_chk("R3 overflow status", 3'd0, 16'h0001);
    rd_chk("R8 read no clear", 3'd0, 16'h0001);
    wr_reg(3'd0, 16'h0000);
    rd_chk("R8 write zero keeps", 3'd0, 16'h0001);
    wr_reg(3'd0, 16'h0001);
    chk("R8 irq after w1c", 32'(irq), 0);
    rd_chk("R8 w1c cleared", 3'd0, 16'h0000);
    wr_reg(3'd4, 16'h0001);
    push_evt(5'd12, 4'h3, 1'b1);
    push_evt(5'd13, 4'hE, 1'b1);
    pop_chk("R1 after flush");
    pop_chk("R1 after flush");

    // R12 register map
    wr_reg(3'd1, 16'hFFFF);
    rd_chk("R12 mask reserved bits", 3'd1, 16'h0007);
    rd_chk("R12 unmapped", 3'd5, 16'h0000);
    rd_chk("R12 thresh", 3'd2, 16'd64);
    rd_chk("R12 term", 3'd3, 16'd60000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule